// File: doc/BRIEF.md
# Super I/O Configuration Unlock Port

This block is the configuration front end of a multi-function peripheral chip, reached through two byte-wide I/O ports: an index port at `BASE_PORT` and a data port at `BASE_PORT+1`. Configuration space starts out locked. The host opens it by writing a four-byte key to the index port. The last byte of the key depends on which of the two standard base ports the chip answers at.

While unlocked, the host writes a register number to the index port and then reads or writes that register through the data port. The registers are:

- the two chip identification bytes;
- a logical-device selector;
- a global flash control byte, which drives the flash window enables, the write enable and the pin select;
- a two-byte base port for the SPI flash controller, visible only while the flash logical device is selected.

Writing the exit value to the exit register locks the space again.

The host side is a simple strobe interface: `io_wr`/`io_rd` pulses with an address. Read data is registered and appears one clock after the read strobe.

The key matcher is a five-state machine:

- `K_LOCKED`: waiting for the first key byte.
- `K_SEEN1`, `K_SEEN2`, `K_SEEN3`: the first one, two or three key bytes have matched.
- `K_OPEN`: configuration space is unlocked.

Its transitions are:

- Advance: the next expected key byte is written to the index port.
- Restart: a byte 0x87 that breaks the sequence goes to `K_SEEN1`.
- Abort: any other breaking byte goes to `K_LOCKED`.
- Unlock: the final key byte goes from `K_SEEN3` to `K_OPEN`.
- Exit: value 0x02 is written to register 0x02, going from `K_OPEN` to `K_LOCKED`.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked, `flash_ctl` equals `CTL_RESET`, `flash_base` equals `FBASE_RESET` and `io_rdata` is 0x00.
- R2: Writing 0x87, 0x01, 0x55 and then a last byte to the index port unlocks the block. The last byte is 0x55 when `BASE_PORT` is 0x2E and 0xAA otherwise (0x4E). `unlocked` is high from the clock edge that takes the last byte.
- R3: A byte that breaks the key returns the matcher to its start, and the block stays locked. A breaking byte of 0x87 counts as the first byte of a new key.
- R4: While locked, data-port reads return 0xFF and data-port writes change no register.
- R5: Writing 0x02 through the data port while the index is 0x02 locks the block. Any other value written there leaves it unlocked.
- R6: Registers 0x20 and 0x21 read the high and low bytes of `CHIP_ID` (0x87, 0x16 by default). Writes to them have no effect.
- R7: Register 0x07 is the readable and writable logical-device selector. When it equals `FLASH_LDN` (7), registers 0x64 and 0x65 read and write the high and low bytes of `flash_base`. With any other device selected they read 0x00 and writes are ignored.
- R8: Register 0x24 is readable and writable and drives `flash_ctl`. Its bit fields are:
  - bit 0: suspend flag;
  - bits 3:1: appear on `flash_win_en`;
  - bit 4: appears on `flash_wr_en`;
  - bit 5: appears on `flash_pin_alt`.
- R9: Read data is registered: `io_rdata` takes the read value on the clock edge that samples `io_rd`. A read of an address other than the two ports returns 0xFF, and a write to such an address has no effect.
- R10: While unlocked, an index-port read returns the current index. While locked, it returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| unlocked | output | 1 | High while configuration space is open |
| flash_ctl | output | 8 | Global flash control register |
| flash_win_en | output | 3 | Memory window enables |
| flash_wr_en | output | 1 | Enable for host writes to the serial flash |
| flash_pin_alt | output | 1 | Selects the alternate flash pin |
| flash_base | output | 16 | Flash controller I/O base port |

## Verification
The key matcher is tried with the exact key, with keys broken at each step by an unrelated byte, and with keys broken by 0x87. These patterns tell a matcher that restarts correctly from one that only aborts or one that ignores mismatches. Two instances with base ports 0x2E and 0x4E share one bus, and each receives the other's final byte. This separates the two key variants and shows that address decoding isolates them.

Long random byte streams over the key alphabet are compared against a bench model of the matcher. Randomised register values are written and read back. Directed accesses while locked, with a non-flash device selected, and to the read-only ID registers show that these writes are dropped.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [2:0] {
        K_LOCKED = 3'd0,
        K_SEEN1  = 3'd1,
        K_SEEN2  = 3'd2,
        K_SEEN3  = 3'd3,
        K_OPEN   = 3'd4
    } key_state_t;

    localparam logic [7:0] KEY_FIRST  = 8'h87;
    localparam logic [7:0] KEY_SECOND = 8'h01;
    localparam logic [7:0] KEY_THIRD  = 8'h55;
    localparam logic [7:0] REG_EXIT   = 8'h02;
    localparam logic [7:0] VAL_EXIT   = 8'h02;
    localparam logic [7:0] REG_LDN    = 8'h07;
    localparam logic [7:0] REG_ID_HI  = 8'h20;
    localparam logic [7:0] REG_ID_LO  = 8'h21;
    localparam logic [7:0] REG_FCTL   = 8'h24;
    localparam logic [7:0] REG_FB_HI  = 8'h64;
    localparam logic [7:0] REG_FB_LO  = 8'h65;
    localparam logic [7:0] BYTE_IDLE  = 8'hFF;

    // The final unlock byte depends on which base port the chip answers at.
    function automatic logic [7:0] key_last(input logic [15:0] base);
        return (base == 16'h002E) ? 8'h55 : 8'hAA;
    endfunction

endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_PORT = 16'h002E
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_idx,
    output logic              hit_dat
);
    localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_PORT);
    localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_PORT + 16'd1);

    always_comb begin
        hit_idx = (addr == IDX_ADDR);
        hit_dat = (addr == DAT_ADDR);
    end
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_pkg::*;
#(
    parameter logic [7:0] LAST_KEY = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    input  logic [7:0] cur_index,
    output logic       unlocked
);
    key_state_t state, state_nxt;

    // Matcher step: advance on the expected byte, restart on 0x87, else abort.
    function automatic key_state_t step(input logic [7:0] expect_b,
                                        input key_state_t advance_to,
                                        input logic [7:0] b);
        if (b == expect_b)       return advance_to;
        else if (b == KEY_FIRST) return K_SEEN1;
        else                     return K_LOCKED;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) state <= K_LOCKED;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            K_LOCKED: if (idx_wr) state_nxt = step(KEY_FIRST,  K_SEEN1, wdata);
            K_SEEN1:  if (idx_wr) state_nxt = step(KEY_SECOND, K_SEEN2, wdata);
            K_SEEN2:  if (idx_wr) state_nxt = step(KEY_THIRD,  K_SEEN3, wdata);
            K_SEEN3:  if (idx_wr) state_nxt = step(LAST_KEY,   K_OPEN,  wdata);
            K_OPEN:   if (dat_wr && cur_index == REG_EXIT && wdata == VAL_EXIT)
                          state_nxt = K_LOCKED;
            default:  state_nxt = K_LOCKED;
        endcase
    end

    always_comb begin
        unlocked = (state == K_OPEN);
    end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_pkg::*;
#(
    parameter logic [7:0]  CTL_RESET   = 8'h0E,
    parameter logic [15:0] FBASE_RESET = 16'h0820,
    parameter logic [15:0] CHIP_ID     = 16'h8716,
    parameter logic [7:0]  FLASH_LDN   = 8'h07
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        unlocked,
    input  logic        idx_wr,
    input  logic        dat_wr,
    input  logic        idx_rd,
    input  logic        dat_rd,
    input  logic        any_rd,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [7:0]  cfg_index,
    output logic [7:0]  cfg_ldn,
    output logic [7:0]  flash_ctl,
    output logic [15:0] flash_base
);
    logic       ldn_is_flash;
    logic [7:0] reg_val;
    logic [7:0] rd_val;

    always_comb begin
        ldn_is_flash = (cfg_ldn == FLASH_LDN);
    end

    always_comb begin
        unique case (cfg_index)
            REG_LDN:   reg_val = cfg_ldn;
            REG_ID_HI: reg_val = CHIP_ID[15:8];
            REG_ID_LO: reg_val = CHIP_ID[7:0];
            REG_FCTL:  reg_val = flash_ctl;
            REG_FB_HI: reg_val = ldn_is_flash ? flash_base[15:8] : 8'h00;
            REG_FB_LO: reg_val = ldn_is_flash ? flash_base[7:0]  : 8'h00;
            default:   reg_val = 8'h00;
        endcase
    end

    always_comb begin
        if (idx_rd)      rd_val = unlocked ? cfg_index : BYTE_IDLE;
        else if (dat_rd) rd_val = unlocked ? reg_val   : BYTE_IDLE;
        else             rd_val = BYTE_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_index  <= 8'h00;
            cfg_ldn    <= 8'h00;
            flash_ctl  <= CTL_RESET;
            flash_base <= FBASE_RESET;
            rdata      <= 8'h00;
        end else begin
            if (any_rd) rdata <= rd_val;
            if (unlocked && idx_wr) cfg_index <= wdata;
            if (unlocked && dat_wr) begin
                unique case (cfg_index)
                    REG_LDN:   cfg_ldn   <= wdata;
                    REG_FCTL:  flash_ctl <= wdata;
                    REG_FB_HI: if (ldn_is_flash) flash_base[15:8] <= wdata;
                    REG_FB_LO: if (ldn_is_flash) flash_base[7:0]  <= wdata;
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] BASE_PORT   = 16'h002E,
    parameter logic [7:0]  CTL_RESET   = 8'h0E,
    parameter logic [15:0] FBASE_RESET = 16'h0820,
    parameter logic [15:0] CHIP_ID     = 16'h8716,
    parameter logic [7:0]  FLASH_LDN   = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              unlocked,
    output logic [7:0]        flash_ctl,
    output logic [2:0]        flash_win_en,
    output logic              flash_wr_en,
    output logic              flash_pin_alt,
    output logic [15:0]       flash_base
);
    localparam logic [7:0] LAST_KEY = key_last(BASE_PORT);

    logic       hit_idx, hit_dat;
    logic       idx_wr, dat_wr, idx_rd, dat_rd;
    logic [7:0] cfg_index, cfg_ldn;

    sio_addr_dec #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT)) u_dec (
        .addr    (io_addr),
        .hit_idx (hit_idx),
        .hit_dat (hit_dat)
    );

    always_comb begin
        idx_wr = io_wr & hit_idx;
        dat_wr = io_wr & hit_dat;
        idx_rd = io_rd & hit_idx;
        dat_rd = io_rd & hit_dat;
    end

    sio_key_fsm #(.LAST_KEY(LAST_KEY)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .wdata     (io_wdata),
        .cur_index (cfg_index),
        .unlocked  (unlocked)
    );

    sio_cfg_regs #(
        .CTL_RESET   (CTL_RESET),
        .FBASE_RESET (FBASE_RESET),
        .CHIP_ID     (CHIP_ID),
        .FLASH_LDN   (FLASH_LDN)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlocked   (unlocked),
        .idx_wr     (idx_wr),
        .dat_wr     (dat_wr),
        .idx_rd     (idx_rd),
        .dat_rd     (dat_rd),
        .any_rd     (io_rd),
        .wdata      (io_wdata),
        .rdata      (io_rdata),
        .cfg_index  (cfg_index),
        .cfg_ldn    (cfg_ldn),
        .flash_ctl  (flash_ctl),
        .flash_base (flash_base)
    );

    always_comb begin
        flash_win_en  = flash_ctl[3:1];
        flash_wr_en   = flash_ctl[4];
        flash_pin_alt = flash_ctl[5];
    end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_PORT = 16'h002E,
    parameter logic [15:0] CHIP_ID   = 16'h8716,
    parameter logic [7:0]  FLASH_LDN = 8'h07
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_rd,
    input logic [ADDR_W-1:0] io_addr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              unlocked,
    input logic [7:0]        flash_ctl,
    input logic [15:0]       flash_base,
    input logic [7:0]        cfg_index,
    input logic [7:0]        cfg_ldn
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_PORT);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_PORT + 16'd1);
    localparam logic [7:0] LAST_B = sio_pkg::key_last(BASE_PORT);

    // R2: opening only follows an index-port write of the final key byte
    a_r2_unlock_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(io_wr) && $past(io_addr) == IDX_A && $past(io_wdata) == LAST_B));

    // R4: locked data reads give 0xFF
    a_r4_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == DAT_A && !unlocked) |=> io_rdata == 8'hFF);

    // R4: nothing changes the flash registers while locked
    a_r4_locked_regs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(flash_ctl) && $stable(flash_base)));

    // R5: the exit write locks the block
    a_r5_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_wr && io_addr == DAT_A && cfg_index == 8'h02 && io_wdata == 8'h02) |=> !unlocked);

    // R6: chip ID high byte reads back
    a_r6_id_high: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_rd && io_addr == DAT_A && cfg_index == 8'h20) |=> io_rdata == CHIP_ID[15:8]);

    // R7: flash base is guarded by the device selector
    a_r7_base_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && cfg_ldn != FLASH_LDN) |=> $stable(flash_base));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_PORT (BASE_PORT),
    .CHIP_ID   (CHIP_ID),
    .FLASH_LDN (FLASH_LDN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .unlocked   (unlocked),
    .flash_ctl  (flash_ctl),
    .flash_base (flash_base),
    .cfg_index  (cfg_index),
    .cfg_ldn    (cfg_ldn)
);

// File: tb/sio_cfg_port_tb.sv
`timescale 1ns/1ps
module sio_cfg_port_tb;
    localparam logic [15:0] P_A = 16'h002E;
    localparam logic [15:0] P_B = 16'h004E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  rdata_a, rdata_b, ctl_a, ctl_b;
    logic        unl_a, unl_b, wr_en_a, wr_en_b, pin_a, pin_b;
    logic [2:0]  win_a, win_b;
    logic [15:0] fb_a, fb_b;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    sio_cfg_port #(.BASE_PORT(P_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(rdata_a), .unlocked(unl_a), .flash_ctl(ctl_a),
        .flash_win_en(win_a), .flash_wr_en(wr_en_a), .flash_pin_alt(pin_a), .flash_base(fb_a));

    sio_cfg_port #(.BASE_PORT(P_B)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(rdata_b), .unlocked(unl_b), .flash_ctl(ctl_b),
        .flash_win_en(win_b), .flash_wr_en(wr_en_b), .flash_pin_alt(pin_b), .flash_base(fb_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] da, output logic [7:0] db);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        da = rdata_a; db = rdata_b;
    endtask

    task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] d);
        io_write(P_A, idx);
        io_write(P_A + 16'd1, d);
    endtask

    task automatic cfg_rd(input logic [7:0] idx, output logic [7:0] d);
        logic [7:0] dummy;
        io_write(P_A, idx);
        io_read(P_A + 16'd1, d, dummy);
    endtask

    task automatic unlock_a();
        io_write(P_A, 8'h87); io_write(P_A, 8'h01);
        io_write(P_A, 8'h55); io_write(P_A, 8'h55);
    endtask

    // Bench model of the key matcher: 0..3 = bytes matched, 4 = open
    function automatic int key_model(input int st, input logic [7:0] b, input logic [7:0] last);
        logic [7:0] want;
        case (st)
            0: want = 8'h87;
            1: want = 8'h01;
            2: want = 8'h55;
            default: want = last;
        endcase
        if (b == want) return st + 1;
        if (b == 8'h87) return 1;
        return 0;
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] ra, rb, v;
        int st;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 locked", unl_a, 0);
        check("R1 flash_ctl", ctl_a, 8'h0E);
        check("R1 flash_base", fb_a, 16'h0820);
        check("R1 rdata", rdata_a, 8'h00);

        // R4 locked data access
        io_read(P_A + 16'd1, ra, rb);
        check("R4 locked read", ra, 8'hFF);
        io_write(P_A, 8'h24);
        io_write(P_A + 16'd1, 8'h55);
        check("R4 locked write ignored", ctl_a, 8'h0E);
        // R10 index read while locked
        io_read(P_A, ra, rb);
        check("R10 locked index read", ra, 8'hFF);

        // R3 broken keys
        io_write(P_A, 8'h87); io_write(P_A, 8'h01); io_write(P_A, 8'h33);
        io_write(P_A, 8'h55); io_write(P_A, 8'h55);
        check("R3 abort stays locked", unl_a, 0);
        io_write(P_A, 8'h87); io_write(P_A, 8'h01); io_write(P_A, 8'h55); io_write(P_A, 8'h87);
        check("R3 restart not open", unl_a, 0);
        io_write(P_A, 8'h01); io_write(P_A, 8'h55); io_write(P_A, 8'h55);
        check("R3 restart then key opens", unl_a, 1);
        check("R9 other base untouched", unl_b, 0);

        // R10 index read while open
        io_write(P_A, 8'h20);
        io_read(P_A, ra, rb);
        check("R10 index read", ra, 8'h20);

        // R6 chip ID, read-only
        cfg_rd(8'h20, v); check("R6 id high", v, 8'h87);
        cfg_rd(8'h21, v); check("R6 id low", v, 8'h16);
        cfg_wr(8'h20, 8'h00);
        cfg_rd(8'h20, v); check("R6 id write ignored", v, 8'h87);

        // R8 flash control
        cfg_wr(8'h24, 8'h3A);
        cfg_rd(8'h24, v); check("R8 readback", v, 8'h3A);
        check("R8 flash_ctl", ctl_a, 8'h3A);
        check("R8 win_en", win_a, 3'b101);
        check("R8 wr_en", wr_en_a, 1);
        check("R8 pin_alt", pin_a, 1);

        // R7 logical device selection
        cfg_wr(8'h07, 8'h03);
        cfg_rd(8'h07, v); check("R7 ldn readback", v, 8'h03);
        cfg_rd(8'h64, v); check("R7 hidden base read", v, 8'h00);
        cfg_wr(8'h64, 8'hAB);
        check("R7 hidden base write ignored", fb_a, 16'h0820);
        cfg_wr(8'h07, 8'h07);
        cfg_rd(8'h64, v); check("R7 base high", v, 8'h08);
        cfg_rd(8'h65, v); check("R7 base low", v, 8'h20);
        cfg_wr(8'h64, 8'h12); cfg_wr(8'h65, 8'h34);
        check("R7 base written", fb_a, 16'h1234);

        // R5 exit register
        cfg_wr(8'h02, 8'h01);
        check("R5 wrong exit value", unl_a, 1);
        io_write(P_A + 16'd1, 8'h02);
        check("R5 exit locks", unl_a, 0);
        io_read(P_A + 16'd1, ra, rb);
        check("R4 read after exit", ra, 8'hFF);

        // R2 second base: final byte 0xAA
        io_write(P_B, 8'h87); io_write(P_B, 8'h01); io_write(P_B, 8'h55); io_write(P_B, 8'h55);
        check("R2 4E rejects 55", unl_b, 0);
        io_write(P_B, 8'h87); io_write(P_B, 8'h01); io_write(P_B, 8'h55); io_write(P_B, 8'hAA);
        check("R2 4E opens on AA", unl_b, 1);
        check("R9 2E not opened by 4E key", unl_a, 0);
        io_write(P_B, 8'h02); io_write(P_B + 16'd1, 8'h02);
        check("R5 4E exit", unl_b, 0);

        // R9 unrelated address
        io_write(16'h0080, 8'h87);
        io_read(16'h0080, ra, rb);
        check("R9 unrelated read", ra, 8'hFF);

        // R2 R3 random key streams against the model
        st = 0;
        for (int i = 0; i < 300; i++) begin
            logic [7:0] b;
            case ($urandom % 5)
                0: b = 8'h87;
                1: b = 8'h01;
                2: b = 8'h55;
                3: b = 8'hAA;
                default: b = 8'($urandom);
            endcase
            io_write(P_A, b);
            st = key_model(st, b, 8'h55);
            check("R3 random stream", unl_a, (st == 4) ? 1 : 0);
            if (st == 4) begin
                logic [7:0] rv;
                rv = 8'($urandom);
                cfg_wr(8'h24, rv);
                cfg_rd(8'h24, v);
                check("R8 random readback", v, rv);
                cfg_wr(8'h02, 8'h02);
                check("R5 random exit", unl_a, 0);
                st = 0;
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule